// File: doc/BRIEF.md
# Configurable Logic Slice

This block is a small programmable logic cluster. It holds four units, and each unit has two 4-input lookup tables with separate outputs. Every table output drives one optional register. A serial configuration chain loads the whole slice. The chain holds the truth tables, the initial register values, one input-steering bit per unit, the wide-multiplexer enables and a carry enable. When the chain is loaded, the slice computes its functions from its pins with no further control.

Each unit serves one side of the slice. The four sides are served clockwise, in the order east, south, west, north. Each side has eight table inputs and four outputs. The clock enable and a 2-bit wide-multiplexer address are shared by all four sides. With these shared pins the slice has 35 input pins and 16 output pins. A carry ripples from the east unit to the north unit.

The second table of each unit can take its lowest input from the first table's output, so the pair forms a two-level function. Optional multiplexer levels merge table outputs into wider functions, using the shared address and then the carry input as selects.

Top module: `logic_slice`

## Requirements
- R1: The configuration chain is 148 bits long. While `cfg_shift_en` is high, each clock shifts `cfg_data_in` into bit 0 and every bit moves up one place. `cfg_data_out` always shows bit 147, so a word sent MSB first is fully in place after 148 clocks. Bit fields: [127:0] truth tables, with table j at [16j+15:16j]; [135:128] initial register values, with bit j for table j; [139:136] steering bit per unit; [143:140] level-1 mux enable per unit; [145:144] level-2 mux enable per pair; [146] level-3 mux enable; [147] carry enable.
- R2: While `cfg_shift_en` is low, the chain contents and `cfg_data_out` do not change, whatever `cfg_data_in` does.
- R3: Unit u drives table 2u (first) from `lut_in[8u+7:8u+4]` and table 2u+1 (second) from `lut_in[8u+3:8u]`. A table outputs the bit of its 16-bit truth table indexed by its 4-bit input value.
- R4: When the steering bit of unit u is 1, the lowest input of the unit's second table is the output of the first table in place of `lut_in[8u]`.
- R5: While reset is active, each clock loads every register with its configured initial value.
- R6: Out of reset, a register captures its combinational output at a clock edge only when `clk_en` is high, and holds otherwise.
- R7: Side u owns `slice_out[4u+3:4u]`. Bit 3 is the first table's register, bit 2 the second table's register, bit 1 the first table's combinational output and bit 0 the second table's combinational output.
- R8: Level 1 of unit u selects its second table's raw output when `mux_addr[0]` is 1, and its first table's output otherwise. Level 2 of pair p selects the level-1 value of unit 2p+1 when `mux_addr[1]` is 1, and of unit 2p otherwise. Level 3 selects pair 1 when `carry_in` is 1, and pair 0 otherwise. An enabled level replaces the first-table output of its unit, with priority level 3, then level 2, then level 1. Level 3 and pair 0 go to unit 0, and pair 1 goes to unit 2.
- R9: The carry into unit 0 is `carry_in`. Each unit passes on the incoming carry when its second table outputs 1, and its first table's output otherwise. `carry_out` is the carry leaving unit 3. When the carry enable is set, each unit's second-table output is XORed with its incoming carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_shift_en | input | 1 | Shift enable for the configuration chain |
| cfg_data_in | input | 1 | Serial configuration data, MSB first |
| cfg_data_out | output | 1 | Top bit of the configuration chain |
| clk_en | input | 1 | Shared register clock enable |
| mux_addr | input | 2 | Shared select for wide-multiplexer levels 1 and 2 |
| lut_in | input | 32 | Table inputs, eight per side |
| carry_in | input | 1 | Carry into unit 0, also the level-3 select |
| carry_out | output | 1 | Carry out of unit 3 |
| slice_out | output | 16 | Four outputs per side |

## Verification
The assertions assume that reset is held low until a first complete configuration has been shifted in. Before that point the chain holds unknown values, and both the initial-value check and the stability checks would be meaningless. The assertions also assume that all data inputs carry known values whenever the registers may capture them. The bench therefore drives every input to zero before the first edge and loads the first word under reset. It changes inputs only on falling clock edges, and later reloads happen with `clk_en` low.

// File: rtl/slice_pkg.sv
package slice_pkg;
  localparam int LUT_K     = 4;
  localparam int NUM_UNITS = 4;
endpackage

// File: rtl/slice_cfg_chain.sv
module slice_cfg_chain #(
  parameter int WIDTH = 148
) (
  input  logic             clk,
  input  logic             shift_en,
  input  logic             data_in,
  output logic [WIDTH-1:0] bits,
  output logic             data_out
);
  logic [WIDTH-1:0] chain_q;
  logic [WIDTH-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[WIDTH-2:0], data_in};
  end

  always_ff @(posedge clk) begin
    if (shift_en) chain_q <= chain_d;
  end

  assign bits     = chain_q;
  assign data_out = chain_q[WIDTH-1];
endmodule

// File: rtl/slice_unit.sv
module slice_unit #(
  parameter int LUT_K = 4
) (
  input  logic [2**LUT_K-1:0] table_first,
  input  logic [2**LUT_K-1:0] table_second,
  input  logic [LUT_K-1:0]    in_first,
  input  logic [LUT_K-1:0]    in_second,
  input  logic                steer_chain,
  input  logic                carry_enable,
  input  logic                carry_i,
  output logic                raw_first,
  output logic                raw_second,
  output logic                comb_second,
  output logic                carry_o
);
  logic [LUT_K-1:0] second_index;

  always_comb begin
    raw_first    = table_first[in_first];
    second_index = in_second;
    if (steer_chain) second_index[0] = raw_first;
    raw_second   = table_second[second_index];
    comb_second  = carry_enable ? (raw_second ^ carry_i) : raw_second;
    carry_o      = raw_second ? carry_i : raw_first;
  end
endmodule

// File: rtl/slice_wide_mux.sv
module slice_wide_mux #(
  parameter int NUM_UNITS = 4
) (
  input  logic [NUM_UNITS-1:0]   raw_first,
  input  logic [NUM_UNITS-1:0]   raw_second,
  input  logic [1:0]             addr,
  input  logic                   top_select,
  input  logic [NUM_UNITS-1:0]   level1_en,
  input  logic [NUM_UNITS/2-1:0] level2_en,
  input  logic                   level3_en,
  output logic [NUM_UNITS-1:0]   comb_first
);
  localparam int NUM_PAIRS = NUM_UNITS / 2;

  logic [NUM_UNITS-1:0] level1;
  logic [NUM_PAIRS-1:0] level2;
  logic                 level3;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_level1
    assign level1[u] = addr[0] ? raw_second[u] : raw_first[u];
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_level2
    assign level2[p] = addr[1] ? level1[2*p+1] : level1[2*p];
  end

  assign level3 = top_select ? level2[1] : level2[0];

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_pick
    always_comb begin
      comb_first[u] = level1_en[u] ? level1[u] : raw_first[u];
      if ((u % 2) == 0) begin
        if (level2_en[u/2]) comb_first[u] = level2[u/2];
      end
      if (u == 0) begin
        if (level3_en) comb_first[u] = level3;
      end
    end
  end
endmodule

// File: rtl/slice_regs.sv
module slice_regs #(
  parameter int COUNT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic [COUNT-1:0] init_value,
  input  logic [COUNT-1:0] data_d,
  output logic [COUNT-1:0] data_q,
  output logic             rst_sync_n
);
  logic             sync_stage;
  logic             sync_out;
  logic [COUNT-1:0] next_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_stage <= 1'b0;
      sync_out   <= 1'b0;
    end else begin
      sync_stage <= 1'b1;
      sync_out   <= sync_stage;
    end
  end

  assign rst_sync_n = sync_out;

  always_comb begin
    if (!sync_out)   next_q = init_value;
    else if (clk_en) next_q = data_d;
    else             next_q = data_q;
  end

  always_ff @(posedge clk) begin
    data_q <= next_q;
  end
endmodule

// File: rtl/logic_slice.sv
module logic_slice #(
  parameter int LUT_K     = slice_pkg::LUT_K,
  parameter int NUM_UNITS = slice_pkg::NUM_UNITS
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_shift_en,
  input  logic                       cfg_data_in,
  output logic                       cfg_data_out,
  input  logic                       clk_en,
  input  logic [1:0]                 mux_addr,
  input  logic [NUM_UNITS*2*LUT_K-1:0] lut_in,
  input  logic                       carry_in,
  output logic                       carry_out,
  output logic [NUM_UNITS*4-1:0]     slice_out
);
  localparam int TT_BITS   = 2**LUT_K;
  localparam int NUM_LUTS  = 2 * NUM_UNITS;
  localparam int NUM_PAIRS = NUM_UNITS / 2;
  localparam int INIT_LSB  = NUM_LUTS * TT_BITS;
  localparam int STEER_LSB = INIT_LSB + NUM_LUTS;
  localparam int LVL1_LSB  = STEER_LSB + NUM_UNITS;
  localparam int LVL2_LSB  = LVL1_LSB + NUM_UNITS;
  localparam int LVL3_BIT  = LVL2_LSB + NUM_PAIRS;
  localparam int CARRY_BIT = LVL3_BIT + 1;
  localparam int CFG_BITS  = CARRY_BIT + 1;

  logic [CFG_BITS-1:0]  cfg_bits;
  logic [NUM_LUTS-1:0]  init_bits;
  logic [NUM_UNITS-1:0] raw_first;
  logic [NUM_UNITS-1:0] raw_second;
  logic [NUM_UNITS-1:0] comb_first;
  logic [NUM_UNITS-1:0] comb_second;
  logic [NUM_UNITS:0]   carry_link;
  logic [NUM_LUTS-1:0]  comb_d;
  logic [NUM_LUTS-1:0]  reg_q;
  logic                 rst_sync_n;

  slice_cfg_chain #(.WIDTH(CFG_BITS)) u_cfg (
    .clk(clk), .shift_en(cfg_shift_en), .data_in(cfg_data_in),
    .bits(cfg_bits), .data_out(cfg_data_out)
  );

  assign init_bits     = cfg_bits[INIT_LSB +: NUM_LUTS];
  assign carry_link[0] = carry_in;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    slice_unit #(.LUT_K(LUT_K)) u_unit (
      .table_first (cfg_bits[(2*u)*TT_BITS +: TT_BITS]),
      .table_second(cfg_bits[(2*u+1)*TT_BITS +: TT_BITS]),
      .in_first    (lut_in[u*2*LUT_K + LUT_K +: LUT_K]),
      .in_second   (lut_in[u*2*LUT_K +: LUT_K]),
      .steer_chain (cfg_bits[STEER_LSB + u]),
      .carry_enable(cfg_bits[CARRY_BIT]),
      .carry_i     (carry_link[u]),
      .raw_first   (raw_first[u]),
      .raw_second  (raw_second[u]),
      .comb_second (comb_second[u]),
      .carry_o     (carry_link[u+1])
    );
    assign comb_d[2*u]     = comb_first[u];
    assign comb_d[2*u+1]   = comb_second[u];
    assign slice_out[4*u+3] = reg_q[2*u];
    assign slice_out[4*u+2] = reg_q[2*u+1];
    assign slice_out[4*u+1] = comb_first[u];
    assign slice_out[4*u]   = comb_second[u];
  end

  assign carry_out = carry_link[NUM_UNITS];

  slice_wide_mux #(.NUM_UNITS(NUM_UNITS)) u_mux (
    .raw_first(raw_first), .raw_second(raw_second),
    .addr(mux_addr), .top_select(carry_in),
    .level1_en(cfg_bits[LVL1_LSB +: NUM_UNITS]),
    .level2_en(cfg_bits[LVL2_LSB +: NUM_PAIRS]),
    .level3_en(cfg_bits[LVL3_BIT]),
    .comb_first(comb_first)
  );

  slice_regs #(.COUNT(NUM_LUTS)) u_regs (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
    .init_value(init_bits), .data_d(comb_d),
    .data_q(reg_q), .rst_sync_n(rst_sync_n)
  );
endmodule

// File: rtl/slice_checker.sv
module slice_checker #(
  parameter int NUM_UNITS = 4,
  parameter int CFG_BITS  = 148
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   rst_sync_n,
  input logic                   clk_en,
  input logic                   cfg_shift_en,
  input logic                   cfg_data_out,
  input logic [CFG_BITS-1:0]    cfg_bits,
  input logic [2*NUM_UNITS-1:0] init_bits,
  input logic [2*NUM_UNITS-1:0] comb_d,
  input logic [4*NUM_UNITS-1:0] slice_out
);
  logic [2*NUM_UNITS-1:0] regs_seen;

  always_comb begin
    for (int u = 0; u < NUM_UNITS; u++) begin
      regs_seen[2*u]   = slice_out[4*u+3];
      regs_seen[2*u+1] = slice_out[4*u+2];
    end
  end

  AST_SHIFT_MOVES_UP: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_shift_en |=> cfg_data_out == $past(cfg_bits[CFG_BITS-2])); // R1

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_shift_en |=> $stable(cfg_bits)); // R2

  AST_RESET_LOADS_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_sync_n |=> regs_seen == $past(init_bits)); // R5

  AST_CE_CAPTURES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    clk_en |=> regs_seen == $past(comb_d)); // R6

  AST_NO_CE_HOLDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !clk_en |=> $stable(regs_seen)); // R6
endmodule

bind logic_slice slice_checker #(.NUM_UNITS(NUM_UNITS), .CFG_BITS(CFG_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n), .clk_en(clk_en),
  .cfg_shift_en(cfg_shift_en), .cfg_data_out(cfg_data_out),
  .cfg_bits(cfg_bits), .init_bits(init_bits), .comb_d(comb_d),
  .slice_out(slice_out)
);

// File: tb/sim_logic_slice.sv
module sim_logic_slice;
  logic        clk;
  logic        rst_n;
  logic        cfg_shift_en;
  logic        cfg_data_in;
  logic        cfg_data_out;
  logic        clk_en;
  logic [1:0]  mux_addr;
  logic [31:0] lut_in;
  logic        carry_in;
  logic        carry_out;
  logic [15:0] slice_out;

  int checks_total = 0;
  int checks_failed = 0;
  logic [147:0] cfg_cur;

  logic_slice u0 (
    .clk(clk), .rst_n(rst_n), .cfg_shift_en(cfg_shift_en),
    .cfg_data_in(cfg_data_in), .cfg_data_out(cfg_data_out),
    .clk_en(clk_en), .mux_addr(mux_addr), .lut_in(lut_in),
    .carry_in(carry_in), .carry_out(carry_out), .slice_out(slice_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks_total++;
    if (act !== exp) begin
      checks_failed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [147:0] make_cfg(input logic [127:0] tt, input logic [7:0] init,
      input logic [3:0] steer, input logic [3:0] l1, input logic [1:0] l2,
      input logic l3, input logic cy);
    return {cy, l3, l2, l1, steer, init, tt};
  endfunction

  // Expected {carry_out, comb[7:0]}, comb[2u]=first table, comb[2u+1]=second (R3, R4, R8, R9)
  function automatic logic [8:0] model(input logic [147:0] c, input logic [31:0] li,
      input logic [1:0] a, input logic ci);
    logic [3:0] r0, r1, f1, c0;
    logic [1:0] f2;
    logic [7:0] comb;
    logic cy, f3;
    cy = ci;
    for (int u = 0; u < 4; u++) begin
      logic [3:0] i0, i1;
      i0 = li[u*8+4 +: 4];
      i1 = li[u*8 +: 4];
      r0[u] = c[2*u*16 + i0];
      if (c[136+u]) i1[0] = r0[u];
      r1[u] = c[(2*u+1)*16 + i1];
      comb[2*u+1] = c[147] ? (r1[u] ^ cy) : r1[u];
      cy = r1[u] ? cy : r0[u];
    end
    for (int u = 0; u < 4; u++) f1[u] = a[0] ? r1[u] : r0[u];
    f2[0] = a[1] ? f1[1] : f1[0];
    f2[1] = a[1] ? f1[3] : f1[2];
    f3 = ci ? f2[1] : f2[0];
    for (int u = 0; u < 4; u++) c0[u] = c[140+u] ? f1[u] : r0[u];
    if (c[144]) c0[0] = f2[0];
    if (c[145]) c0[2] = f2[1];
    if (c[146]) c0[0] = f3;
    for (int u = 0; u < 4; u++) comb[2*u] = c0[u];
    return {cy, comb};
  endfunction

  // R7 pin positions
  function automatic logic [7:0] comb_of(input logic [15:0] p);
    logic [7:0] r;
    for (int u = 0; u < 4; u++) begin r[2*u] = p[4*u+1]; r[2*u+1] = p[4*u]; end
    return r;
  endfunction

  function automatic logic [7:0] regs_of(input logic [15:0] p);
    logic [7:0] r;
    for (int u = 0; u < 4; u++) begin r[2*u] = p[4*u+3]; r[2*u+1] = p[4*u+2]; end
    return r;
  endfunction

  task automatic load_cfg(input logic [147:0] v, input logic verify_out);
    int bad = 0;
    for (int i = 147; i >= 0; i--) begin
      @(negedge clk);
      if (verify_out && cfg_data_out !== cfg_cur[i]) bad++;
      cfg_data_in  = v[i];
      cfg_shift_en = 1'b1;
    end
    @(negedge clk);
    cfg_shift_en = 1'b0;
    cfg_cur = v;
    if (verify_out) check("R1 old word leaves MSB first", bad, 0);
  endtask

  task automatic drive(input logic [31:0] li, input logic [1:0] a, input logic ci);
    @(negedge clk);
    lut_in = li; mux_addr = a; carry_in = ci;
    #2;
  endtask

  task automatic run_patterns(input string req, input int n);
    for (int k = 0; k < n; k++) begin
      logic [8:0] e;
      drive($urandom, 2'($urandom), 1'($urandom));
      e = model(cfg_cur, lut_in, mux_addr, carry_in);
      check(req, {23'd0, carry_out, comb_of(slice_out)}, {23'd0, e});
    end
  endtask

  task automatic test_reset_init();
    logic [147:0] v;
    v = make_cfg({$urandom, $urandom, $urandom, $urandom}, 8'b1011_0010, 4'h0, 4'h0, 2'b0, 1'b0, 1'b1);
    load_cfg(v, 1'b0);
    @(posedge clk); #2;
    check("R5 registers hold init under reset", regs_of(slice_out), 8'b1011_0010);
    check("R1 data_out shows bit 147", cfg_data_out, v[147]);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R6 no capture with clk_en low", regs_of(slice_out), 8'b1011_0010);
  endtask

  task automatic test_plain();
    logic [147:0] v;
    v = make_cfg({$urandom, $urandom, $urandom, $urandom}, 8'h00, 4'h0, 4'h0, 2'b0, 1'b0, 1'b0);
    load_cfg(v, 1'b1);
    run_patterns("R3 R7 R9 table lookup and carry ripple", 6);
    drive(32'h0000_F00F, 2'b00, 1'b0);
    check("R3 unit0 fixed index", comb_of(slice_out) & 8'h03,
          {6'd0, cfg_cur[16 + 15], cfg_cur[0]});
  endtask

  task automatic test_steer();
    logic [147:0] v;
    // first tables all-ones, second tables pass their input bit 0
    v = make_cfg({4{16'hAAAA, 16'hFFFF}}, 8'h00, 4'b0101, 4'h0, 2'b0, 1'b0, 1'b0);
    load_cfg(v, 1'b1);
    drive(32'h0000_0000, 2'b00, 1'b0);
    check("R4 steered units see first output", comb_of(slice_out), 8'b0111_0111);
    run_patterns("R4 steering random", 4);
  endtask

  task automatic test_wide();
    logic [147:0] v;
    v = make_cfg({$urandom, $urandom, $urandom, $urandom}, 8'h00, 4'h0, 4'hF, 2'b00, 1'b0, 1'b0);
    load_cfg(v, 1'b1);
    run_patterns("R8 level1", 4);
    cfg_cur = make_cfg(cfg_cur[127:0], 8'h00, 4'h0, 4'hF, 2'b11, 1'b0, 1'b0);
    load_cfg(cfg_cur, 1'b0);
    run_patterns("R8 level2", 4);
    cfg_cur = make_cfg(cfg_cur[127:0], 8'h00, 4'h0, 4'hF, 2'b11, 1'b1, 1'b0);
    load_cfg(cfg_cur, 1'b0);
    run_patterns("R8 level3", 6);
  endtask

  task automatic test_carry();
    logic [147:0] v;
    // first tables constant 0, second tables constant 1: pure propagate
    v = make_cfg({4{16'hFFFF, 16'h0000}}, 8'h00, 4'h0, 4'h0, 2'b0, 1'b0, 1'b1);
    load_cfg(v, 1'b1);
    drive(32'h0, 2'b00, 1'b1);
    check("R9 propagate carry_out", carry_out, 1'b1);
    check("R9 sum bits inverted", comb_of(slice_out), 8'b0000_0000);
    drive(32'h0, 2'b00, 1'b0);
    check("R9 propagate zero", {carry_out, comb_of(slice_out)}, {1'b0, 8'b1010_1010});
    v = make_cfg({$urandom, $urandom, $urandom, $urandom}, 8'h00, 4'h0, 4'h0, 2'b0, 1'b0, 1'b1);
    load_cfg(v, 1'b1);
    run_patterns("R9 random carry", 6);
  endtask

  task automatic test_capture();
    logic [8:0] e;
    logic [7:0] held;
    drive(32'h1234_5678, 2'b01, 1'b1);
    e = model(cfg_cur, lut_in, mux_addr, carry_in);
    clk_en = 1'b1;
    @(posedge clk); #2;
    check("R6 capture on clk_en", regs_of(slice_out), e[7:0]);
    drive(32'h8765_4321, 2'b10, 1'b0);
    e = model(cfg_cur, lut_in, mux_addr, carry_in);
    @(posedge clk); #2;
    check("R6 capture second", regs_of(slice_out), e[7:0]);
    held = e[7:0];
    @(negedge clk); clk_en = 1'b0;
    drive(~32'h8765_4321, 2'b01, 1'b1);
    @(posedge clk); #2;
    check("R6 hold without clk_en", regs_of(slice_out), held);
  endtask

  task automatic test_hold_cfg();
    logic [7:0] comb_before;
    logic out_before;
    comb_before = comb_of(slice_out);
    out_before  = cfg_data_out;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk); cfg_data_in = ~cfg_data_in;
    end
    #2;
    check("R2 data_out held", cfg_data_out, out_before);
    check("R2 function held", comb_of(slice_out), comb_before);
  endtask

  task automatic test_reset_again();
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #2;
    check("R5 reset reloads init", regs_of(slice_out), cfg_cur[135:128]);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b1; cfg_shift_en = 1'b0; cfg_data_in = 1'b0; clk_en = 1'b0;
    mux_addr = 2'b00; lut_in = 32'h0; carry_in = 1'b0; cfg_cur = '0;
    #1 rst_n = 1'b0;
    test_reset_init();
    test_plain();
    test_steer();
    test_wide();
    test_carry();
    test_capture();
    test_hold_cfg();
    test_reset_again();
    $display("%0d/%0d checks passed", checks_total - checks_failed, checks_total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks_total++;
    checks_failed++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks_total - checks_failed, checks_total);
    $finish;
  end
endmodule